// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block turns a linked list of 16-byte scatter-gather descriptors in host memory into a series of transfer commands for a separate data mover. A controller starts it with two addresses: the first descriptor and the command packet. The walker then reads each descriptor one byte at a time over a simple read port. It issues one transfer request per descriptor and waits for that transfer's completion report. It follows each descriptor's next pointer until it reaches a descriptor whose end flag is set.

When the walk stops, the block writes one response byte to offset 0 of the command packet. The byte reports success, a device-reported transfer error, or a host bus fault, and the block then returns to idle. Moving data and mastering the bus are done elsewhere. This block only produces the commands and reacts to their results.

All multi-byte descriptor fields are little-endian. Lengths are stored in 8-byte units. Descriptor addresses must sit on 8-byte boundaries.

Top module: `prd_chain_walker`

## Requirements
- R1: After reset, `busy`, `rd_req`, `xfer_valid` and `wr_valid` are all low.
- R2: Each descriptor is read as 16 single-byte reads at ascending addresses, from the descriptor address up to that address plus 15. Only one read is outstanding at a time, and `rd_req` and `rd_addr` hold steady until `rd_rvalid` returns the byte.
- R3: `xfer_addr` equals descriptor bytes 0..3 read little-endian. `xfer_bytes` equals descriptor bytes 4..7 read little-endian and multiplied by 8.
- R4: `xfer_to_dev` is bit 5 of descriptor byte 8. `xfer_ordered` is bit 4 of byte 8. `xfer_mode` is bits 3:0 of byte 9. The upper nibble of byte 9 and the contents of bytes 10 and 11 have no effect.
- R5: A transfer request stays valid and stable until `xfer_ready`. After acceptance, nothing further is read or issued until `xfer_done` is seen.
- R6: When a transfer on a descriptor without the end flag completes without error, the next descriptor is fetched from the address held in bytes 12..15, read little-endian.
- R7: A descriptor with bit 7 of byte 8 set ends the chain. Its next pointer is ignored, and on a clean completion the byte 0x01 is written to the packet address.
- R8: `xfer_done` together with `xfer_err` stops the walk at once. The byte 0x09 is written to the packet address, and no further descriptor is read.
- R9: A first or next descriptor address whose low 3 bits are not zero causes no read and no transfer for that descriptor, and the byte 0x03 is written to the packet address.
- R10: `start` has no effect while `busy` is high. The packet address and the chain in progress are unchanged.
- R11: The response write stays valid and stable until `wr_ready`. `busy` is low in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; sampled only when idle |
| first_prd_addr | input | 32 | Address of the first descriptor |
| pkt_addr | input | 32 | Packet address that receives the response byte |
| busy | output | 1 | A walk is in progress |
| rd_req | output | 1 | Descriptor byte read request |
| rd_addr | output | 32 | Descriptor byte address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 8 | Returned descriptor byte |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_bytes | output | 35 | Transfer length in bytes |
| xfer_to_dev | output | 1 | Data moves toward the device |
| xfer_ordered | output | 1 | Ordering flag copied from the descriptor |
| xfer_mode | output | 4 | DMA mode for this transfer |
| xfer_done | input | 1 | Current transfer finished |
| xfer_err | input | 1 | With `xfer_done`: transfer failed |
| wr_valid | output | 1 | Response write valid |
| wr_ready | input | 1 | Response write accepted |
| wr_addr | output | 32 | Response write address |
| wr_data | output | 8 | Response byte |

## Verification
A wrong byte index in the fetcher shows up at the transfer port on the first descriptor. The address, length or flags come out of place about 32 cycles after `start`. A wrong state in the control sequence shows up as extra or missing descriptor reads, or as a wrong response code at the end of the chain. That can appear only after a full chain of fetches, so the bench compares the complete read-address log and the transfer count for every walk. Alignment faults and ignored starts are judged by the absence of reads and by the packet address that the response write targets.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int PRD_BYTES  = 16;
  localparam int PRD_AW     = 32;
  localparam int PRD_LW     = 32;
  localparam int PRD_MW     = 4;
  localparam int FLG_ORD    = 4;
  localparam int FLG_OUT    = 5;
  localparam int FLG_LAST   = 7;
  localparam logic [7:0] RSP_OK      = 8'h01;
  localparam logic [7:0] RSP_BUS_ERR = 8'h03;
  localparam logic [7:0] RSP_DEV_ERR = 8'h09;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_RESP
  } walk_state_e;

  typedef struct packed {
    logic [PRD_AW-1:0] buf_addr;
    logic [PRD_LW-1:0] len_units;
    logic              last;
    logic              outward;
    logic              ordered;
    logic [PRD_MW-1:0] mode;
    logic [PRD_AW-1:0] next_addr;
  } prd_fields_t;
endpackage

// File: rtl/prd_byte_fetch.sv
module prd_byte_fetch #(
  parameter int NBYTES = 16,
  parameter int AW     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [AW-1:0]         base,
  output logic                  rd_req,
  output logic [AW-1:0]         rd_addr,
  input  logic                  rd_rvalid,
  input  logic [7:0]            rd_rdata,
  output logic                  done,
  output logic [NBYTES-1:0][7:0] bytes
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

  logic          active_q, active_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] base_q;
  logic          cap;

  assign cap = active_q && rd_rvalid;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    done     = 1'b0;
    if (go) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (cap) begin
      idx_d = idx_q + IW'(1);
      if (idx_q == LAST_IDX) begin
        active_d = 1'b0;
        done     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base_q <= '0;
    else if (go) base_q <= base;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bytes[g] <= '0;
      else if (cap && idx_q == IW'(g))     bytes[g] <= rd_rdata;
    end
  end

  assign rd_req  = active_q;
  assign rd_addr = base_q + AW'(idx_q);
endmodule

// File: rtl/prd_field_decode.sv
module prd_field_decode
  import prd_walk_pkg::*;
(
  input  logic [PRD_BYTES-1:0][7:0] raw,
  output prd_fields_t               f
);
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      f.buf_addr[8*k +: 8]  = raw[k];
      f.len_units[8*k +: 8] = raw[4 + k];
      f.next_addr[8*k +: 8] = raw[12 + k];
    end
    f.last    = raw[8][FLG_LAST];
    f.outward = raw[8][FLG_OUT];
    f.ordered = raw[8][FLG_ORD];
    f.mode    = raw[9][PRD_MW-1:0];
  end
endmodule

// File: rtl/prd_walk_ctrl.sv
module prd_walk_ctrl
  import prd_walk_pkg::*;
#(
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PRD_AW-1:0] first_addr,
  input  logic [PRD_AW-1:0] pkt_addr,
  input  logic              fetch_done,
  input  prd_fields_t       f,
  output logic              fetch_go,
  output logic [PRD_AW-1:0] fetch_base,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PRD_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy
);
  walk_state_e       state_q, state_d;
  logic [PRD_AW-1:0] pkt_q;
  logic              pkt_en;
  logic [7:0]        rsp_q, rsp_d;

  function automatic logic misaligned(input logic [PRD_AW-1:0] a);
    return |a[ALIGN_BITS-1:0];
  endfunction

  always_comb begin
    state_d  = state_q;
    rsp_d    = rsp_q;
    pkt_en   = 1'b0;
    fetch_go = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        pkt_en = 1'b1;
        if (misaligned(first_addr)) begin
          rsp_d   = RSP_BUS_ERR;
          state_d = ST_RESP;
        end else begin
          fetch_go = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: if (fetch_done) state_d = ST_ISSUE;
      ST_ISSUE: if (xfer_ready) state_d = ST_WAIT;
      ST_WAIT: if (xfer_done) begin
        if (xfer_err) begin
          rsp_d   = RSP_DEV_ERR;
          state_d = ST_RESP;
        end else if (f.last) begin
          rsp_d   = RSP_OK;
          state_d = ST_RESP;
        end else if (misaligned(f.next_addr)) begin
          rsp_d   = RSP_BUS_ERR;
          state_d = ST_RESP;
        end else begin
          fetch_go = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_RESP: if (wr_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (pkt_en) pkt_q <= pkt_addr;
  end

  assign fetch_base = (state_q == ST_IDLE) ? first_addr : f.next_addr;
  assign xfer_valid = (state_q == ST_ISSUE);
  assign wr_valid   = (state_q == ST_RESP);
  assign wr_addr    = pkt_q;
  assign wr_data    = rsp_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/prd_chain_walker.sv
module prd_chain_walker
  import prd_walk_pkg::*;
#(
  parameter int ALIGN_BITS = 3,
  parameter int LEN_SHIFT  = 3,
  localparam int BYTES_W   = PRD_LW + LEN_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PRD_AW-1:0]  first_prd_addr,
  input  logic [PRD_AW-1:0]  pkt_addr,
  output logic               busy,
  output logic               rd_req,
  output logic [PRD_AW-1:0]  rd_addr,
  input  logic               rd_rvalid,
  input  logic [7:0]         rd_rdata,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [PRD_AW-1:0]  xfer_addr,
  output logic [BYTES_W-1:0] xfer_bytes,
  output logic               xfer_to_dev,
  output logic               xfer_ordered,
  output logic [PRD_MW-1:0]  xfer_mode,
  input  logic               xfer_done,
  input  logic               xfer_err,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [PRD_AW-1:0]  wr_addr,
  output logic [7:0]         wr_data
);
  logic                      fetch_go, fetch_done;
  logic [PRD_AW-1:0]         fetch_base;
  logic [PRD_BYTES-1:0][7:0] raw;
  prd_fields_t               f;

  prd_byte_fetch #(.NBYTES(PRD_BYTES), .AW(PRD_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(fetch_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .done(fetch_done), .bytes(raw)
  );

  prd_field_decode u_dec (.raw(raw), .f(f));

  prd_walk_ctrl #(.ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_prd_addr),
    .pkt_addr(pkt_addr), .fetch_done(fetch_done), .f(f),
    .fetch_go(fetch_go), .fetch_base(fetch_base),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );

  assign xfer_addr    = f.buf_addr;
  assign xfer_bytes   = {f.len_units, {LEN_SHIFT{1'b0}}};
  assign xfer_to_dev  = f.outward;
  assign xfer_ordered = f.ordered;
  assign xfer_mode    = f.mode;
endmodule

// File: rtl/prd_chain_walker_chk.sv
module prd_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_rvalid,
  input logic        xfer_valid,
  input logic        xfer_ready,
  input logic [31:0] xfer_addr,
  input logic [34:0] xfer_bytes,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [7:0]  wr_data
);
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_rvalid |=> rd_req && $stable(rd_addr));

  p_len_units_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_bytes[2:0] == 3'b000);

  p_xfer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_bytes));

  p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_req, xfer_valid, wr_valid}) <= 1);

  p_rsp_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data == 8'h01 || wr_data == 8'h03 || wr_data == 8'h09));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

  p_idle_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !busy);

  p_busy_cover_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || xfer_valid || wr_valid) |-> busy);
endmodule

bind prd_chain_walker prd_chain_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_rvalid(rd_rvalid), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/prd_chain_walker_tb.sv
module prd_chain_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_prd_addr = '0;
  logic [31:0] pkt_addr = '0;
  logic        busy, rd_req, xfer_valid, xfer_to_dev, xfer_ordered, wr_valid;
  logic [31:0] rd_addr, xfer_addr, wr_addr;
  logic        rd_rvalid = 1'b0;
  logic [7:0]  rd_rdata = '0;
  logic        xfer_ready = 1'b0, xfer_done = 1'b0, xfer_err = 1'b0, wr_ready = 1'b0;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic [7:0]  wr_data;

  always #5 clk = ~clk;

  prd_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_prd_addr(first_prd_addr),
    .pkt_addr(pkt_addr), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_to_dev(xfer_to_dev), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // byte memory with one-cycle read return and an address log
  logic [7:0]  mem  [0:255];
  logic [31:0] flog [0:1023];
  int          fcnt = 0;
  always @(posedge clk) begin
    rd_rvalid <= rd_req && !rd_rvalid;
    rd_rdata  <= mem[rd_addr[7:0]];
    if (rd_req && !rd_rvalid) begin
      if (fcnt < 1024) flog[fcnt] <= rd_addr;
      fcnt <= fcnt + 1;
    end
  end

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done_all = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done_all) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] ba, input logic [31:0] len,
                          input logic [7:0] flg, input logic [3:0] mode, input logic [31:0] nxt);
    for (int k = 0; k < 4; k++) begin
      mem[a + k]      = ba[8*k +: 8];
      mem[a + 4 + k]  = len[8*k +: 8];
      mem[a + 12 + k] = nxt[8*k +: 8];
    end
    mem[a + 8]  = flg;
    mem[a + 9]  = {4'hA, mode};
    mem[a + 10] = 8'h5A;
    mem[a + 11] = 8'hC3;
  endtask

  // results of the last walk
  logic [31:0] xa [0:7];
  logic [34:0] xb [0:7];
  logic        xo [0:7];
  logic        xr [0:7];
  logic [3:0]  xm [0:7];
  int          nx, f0;
  logic [31:0] got_wa;
  logic [7:0]  got_wd;

  task automatic run_chain(input logic [31:0] first, input logic [31:0] pkt,
                           input int err_at, input bit stall, input bit inject);
    bit fin;
    int guard;
    nx = 0; fin = 1'b0; guard = 0;
    f0 = fcnt;
    @(negedge clk);
    first_prd_addr = first; pkt_addr = pkt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && guard < 20000) begin
      if (xfer_valid) begin
        if (nx < 8) begin
          xa[nx] = xfer_addr; xb[nx] = xfer_bytes; xo[nx] = xfer_to_dev;
          xr[nx] = xfer_ordered; xm[nx] = xfer_mode;
        end
        if (stall) begin
          repeat (2) @(negedge clk);
          chk(xfer_valid && xfer_addr == xa[nx], "R5 request held while not ready", {63'd0, xfer_valid}, 64'd1);
        end
        if (inject && nx == 0) begin
          first_prd_addr = 32'h0000_0008; pkt_addr = 32'h0000_2222; start = 1'b1;
        end
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        if (stall) chk(!rd_req && !xfer_valid && !wr_valid, "R5 waits for done", {61'd0, rd_req, xfer_valid, wr_valid}, 64'd0);
        xfer_done = 1'b1; xfer_err = (nx == err_at);
        @(negedge clk);
        xfer_done = 1'b0; xfer_err = 1'b0;
        nx++;
      end else if (wr_valid) begin
        got_wa = wr_addr; got_wd = wr_data;
        if (stall) begin
          @(negedge clk);
          chk(wr_valid && wr_data == got_wd && wr_addr == got_wa, "R11 write held", {63'd0, wr_valid}, 64'd1);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        fin = 1'b1;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(fin, "R11 walk finished", {63'd0, fin}, 64'd1);
    chk(!busy, "R11 idle after write", {63'd0, busy}, 64'd0);
  endtask

  function automatic bit seq_ok(input int from, input logic [31:0] base);
    for (int k = 0; k < 16; k++)
      if (flog[from + k] != base + 32'(k)) return 1'b0;
    return 1'b1;
  endfunction

  typedef struct packed {
    logic [31:0] ba;
    logic [31:0] len;
    logic [7:0]  flg;
    logic [3:0]  mode;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{ba: 32'h8000_0000, len: 32'h0000_0001, flg: 8'h80, mode: 4'h0},
    '{ba: 32'h1234_5678, len: 32'h0000_0200, flg: 8'hB0, mode: 4'h6},
    '{ba: 32'hDEAD_BEE8, len: 32'h1FFF_FFFF, flg: 8'hA0, mode: 4'hF},
    '{ba: 32'h0000_0040, len: 32'h0000_0000, flg: 8'h90, mode: 4'h3}
  };

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !xfer_valid && !wr_valid, "R1 reset outputs low",
        {60'd0, busy, rd_req, xfer_valid, wr_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table: single terminal descriptor, nonzero next pointer, noisy bytes 9..11
    foreach (VEC[i]) begin
      put_desc(16, VEC[i].ba, VEC[i].len, VEC[i].flg, VEC[i].mode, 32'h0000_0050);
      run_chain(32'h10, 32'h1000 + 32'(i), -1, i[0], 1'b0);
      chk(nx == 1, "R7 one transfer per terminal desc", 64'(nx), 64'd1);
      chk(xa[0] == VEC[i].ba, "R3 transfer address", 64'(xa[0]), 64'(VEC[i].ba));
      chk(xb[0] == ({3'b000, VEC[i].len} << 3), "R3 byte count", 64'(xb[0]), 64'({3'b000, VEC[i].len} << 3));
      chk(xo[0] == VEC[i].flg[5] && xr[0] == VEC[i].flg[4], "R4 direction and ordering",
          {62'd0, xo[0], xr[0]}, {62'd0, VEC[i].flg[5], VEC[i].flg[4]});
      chk(xm[0] == VEC[i].mode, "R4 mode nibble", 64'(xm[0]), 64'(VEC[i].mode));
      chk(fcnt - f0 == 16 && seq_ok(f0, 32'h10), "R2 sixteen ascending reads, R7 next ignored", 64'(fcnt - f0), 64'd16);
      chk(got_wd == 8'h01 && got_wa == 32'h1000 + 32'(i), "R7 success response", {24'd0, got_wa, got_wd}, {24'd0, 32'h1000 + 32'(i), 8'h01});
    end

    // three-descriptor chain with stalls
    put_desc(8'h40, 32'hA000_0000, 32'h10, 8'h10, 4'h2, 32'h0000_0060);
    put_desc(8'h60, 32'hA000_1000, 32'h20, 8'h30, 4'h4, 32'h0000_0080);
    put_desc(8'h80, 32'hA000_2000, 32'h30, 8'h80, 4'h5, 32'h0000_0000);
    run_chain(32'h40, 32'h3000, -1, 1'b1, 1'b0);
    chk(nx == 3, "R6 chain of three transfers", 64'(nx), 64'd3);
    chk(xa[1] == 32'hA000_1000 && xa[2] == 32'hA000_2000, "R6 follows next pointers", 64'(xa[2]), 64'hA000_2000);
    chk(fcnt - f0 == 48 && seq_ok(f0 + 16, 32'h60) && seq_ok(f0 + 32, 32'h80), "R6 fetch addresses", 64'(fcnt - f0), 64'd48);
    chk(got_wd == 8'h01, "R7 chain success", 64'(got_wd), 64'h01);

    // error on second transfer
    run_chain(32'h40, 32'h3100, 1, 1'b0, 1'b0);
    chk(nx == 2 && fcnt - f0 == 32, "R8 stops after error", 64'(fcnt - f0), 64'd32);
    chk(got_wd == 8'h09 && got_wa == 32'h3100, "R8 error response", 64'(got_wd), 64'h09);

    // error on the terminal descriptor
    run_chain(32'h80, 32'h3200, 0, 1'b0, 1'b0);
    chk(got_wd == 8'h09, "R8 error on last descriptor", 64'(got_wd), 64'h09);

    // misaligned first descriptor
    run_chain(32'h44, 32'h3300, -1, 1'b0, 1'b0);
    chk(nx == 0 && fcnt == f0, "R9 no read or transfer", 64'(fcnt - f0), 64'd0);
    chk(got_wd == 8'h03 && got_wa == 32'h3300, "R9 bus fault response", 64'(got_wd), 64'h03);

    // misaligned next pointer
    put_desc(8'hA0, 32'hB000_0000, 32'h8, 8'h00, 4'h1, 32'h0000_00C4);
    run_chain(32'hA0, 32'h3400, -1, 1'b0, 1'b0);
    chk(nx == 1 && fcnt - f0 == 16, "R9 next not fetched", 64'(fcnt - f0), 64'd16);
    chk(got_wd == 8'h03, "R9 bus fault on next", 64'(got_wd), 64'h03);

    // start while busy
    run_chain(32'h80, 32'h3500, -1, 1'b0, 1'b1);
    chk(got_wa == 32'h3500 && got_wd == 8'h01, "R10 start ignored while busy", 64'(got_wa), 64'h3500);
    repeat (3) @(negedge clk);
    chk(!busy && fcnt - f0 == 16 && nx == 1, "R10 no second walk", 64'(fcnt - f0), 64'd16);

    done_all = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule